// File: doc/BRIEF.md
# Multiply/Divide Coprocessor

This block is an arithmetic helper for a small 8-bit controller. Software places operand bytes in byte-wide registers and starts an operation. The unit then works for several cycles with busy raised, and software reads back result, remainder and status bytes. It covers 32/16 and 16/16 division, 16x16 multiplication, 32-bit normalization and 32-bit shifts. There are two ways to start an operation. In legacy mode, the register write itself picks the operation. In opcode mode, one command byte picks it and can also ask for signed multiply or divide, or an arithmetic shift.

Write register map (4-bit address):
- 0 to 3: operand A bytes, least significant first.
- 4: operand B low byte.
- 5: B high byte, and starts a legacy divide.
- 6: B high byte, and starts a legacy multiply.
- 7: legacy shift command. Bits [4:0] are the count, bit 5 selects right, bit 6 selects normalize. The count is also stored.
- 8: opcode command.
- 9: shift count only.
- 10: B high byte only.

Read map (3-bit address):
- 0 to 3: result bytes, least significant first.
- 4 to 5: remainder bytes.
- 6: status. Bit 7 is busy, bit 6 is the divide-by-zero error, bits [4:0] are the normalize count.

The control FSM has four states:
- IDLE waits for a start (transition *launch*).
- PREP takes operand magnitudes and either takes *skip* straight to FIX or takes *iterate* into RUN.
- RUN does one step per cycle and takes *finish* to FIX on its last step.
- FIX applies signs, loads the result and remainder registers, and takes *retire* back to IDLE.

Top module: `mdu_top`

## Requirements
- R1: After reset, busy is low and all seven readable bytes (addresses 0 to 6) read 0.
- R2: A write to address 5, when operand A byte 2 or 3 has been written since the last start, starts an unsigned 32/16 divide. It yields the 32-bit quotient in result and the 16-bit remainder in the remainder bytes, with busy high for exactly 34 cycles.
- R3: A write to address 5, when neither A byte 2 nor 3 has been written since the last start, starts an unsigned divide of A[15:0] by B. It yields the 16-bit quotient in result bytes 0 to 1, zeros in bytes 2 to 3, and the remainder, with busy high for 18 cycles.
- R4: A write to address 6 starts an unsigned 16x16 multiply of A[15:0] by B. It yields the 32-bit product, remainder 0, and busy high for 18 cycles.
- R5: A write to address 7 with bit 6 set normalizes A. The result is A shifted left until bit 31 is 1, and status[4:0] holds the shift count. Busy lasts count+2 cycles. An A of zero gives result 0, count 0 and 2 busy cycles.
- R6: A write to address 7 with bit 6 clear shifts A logically by data[4:0], to the right if bit 5 is set and otherwise to the left. Busy lasts count+2 cycles, and a count of 0 returns A unchanged after 2 cycles.
- R7: A write to address 8 starts the operation given by bits [2:0]: 0 = 32/16 divide, 1 = 16/16 divide, 2 = multiply, 3 = normalize, 4 = left shift, 5 = right shift. Bit 3 selects signed. Shifts use the count last written at address 9 or 7. Codes 6 and 7 start nothing and leave every readable byte unchanged.
- R8: A signed multiply (opcode 2 with bit 3) treats A[15:0] and B as two's complement and returns the 32-bit two's complement product.
- R9: Signed divides (opcode 0 or 1 with bit 3) truncate the quotient toward zero, and the remainder takes the sign of the dividend.
- R10: A signed right shift (opcode 5 with bit 3) fills with copies of bit 31. A signed left shift gives the same result as the logical one.
- R11: A divide with B equal to 0 takes 2 busy cycles. It sets status bit 6, returns an all-ones quotient of the operation's width, and returns the remainder A[15:0]. The next start clears status bit 6.
- R12: Every write made while busy is high is ignored: it changes no operand and starts nothing. Result bytes change only when an operation retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data byte (combinational) |
| busy | output | 1 | High while an operation is in progress |

## Verification
The assertions check these properties on every cycle:
- A start always raises busy on the next cycle.
- A write during busy leaves both operand registers unchanged.
- The result register never moves while the unit is idle.
- The error flag only rises inside an operation.
- No operation holds busy longer than the 32-bit divide does.

The bench scenarios show the rest: correct quotients, products, sign fixes, normalize counts and exact per-operation latencies. They also cover the legacy selection between the two divide widths, which depends on the history of operand writes. That history is invisible to a single-cycle property.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int BYTE_W  = 8;
    localparam int A_W     = 32;
    localparam int B_W     = 16;
    localparam int C_W     = 5;
    localparam int ADDR_W  = 4;
    localparam int RADDR_W = 3;
    localparam int A_BYTES = A_W / BYTE_W;
    localparam int B_BYTES = B_W / BYTE_W;
    localparam int IT_W    = $clog2(A_W) + 1;

    localparam logic [ADDR_W-1:0] ADR_BLO  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_BDIV = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_BMUL = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_SHF  = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_OPC  = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_BHI  = 4'd10;

    typedef enum logic [2:0] {
        OP_DIV32 = 3'd0,
        OP_DIV16 = 3'd1,
        OP_MUL   = 3'd2,
        OP_NORM  = 3'd3,
        OP_SHL   = 3'd4,
        OP_SHR   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN,
        ST_FIX
    } st_e;
endpackage

// File: rtl/mdu_regs.sv
module mdu_regs
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [A_W-1:0]    opa,
    output logic [B_W-1:0]    opb,
    output logic [C_W-1:0]    shcnt,
    output logic              start,
    output op_e               op,
    output logic              sgn
);
    logic ahi;
    logic wr_ok;

    assign wr_ok = wr_en && !busy;

    // start decode: legacy triggers and the opcode command
    always_comb begin
        start = 1'b0;
        op    = OP_DIV32;
        sgn   = 1'b0;
        if (wr_ok) begin
            case (wr_addr)
                ADR_BDIV: begin
                    start = 1'b1;
                    op    = ahi ? OP_DIV32 : OP_DIV16;
                end
                ADR_BMUL: begin
                    start = 1'b1;
                    op    = OP_MUL;
                end
                ADR_SHF: begin
                    start = 1'b1;
                    op    = wr_data[6] ? OP_NORM : (wr_data[5] ? OP_SHR : OP_SHL);
                end
                ADR_OPC: begin
                    if (wr_data[2:0] <= 3'd5) begin
                        start = 1'b1;
                        op    = op_e'(wr_data[2:0]);
                        sgn   = wr_data[3];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa   <= '0;
            opb   <= '0;
            shcnt <= '0;
            ahi   <= 1'b0;
        end else if (wr_ok) begin
            for (int i = 0; i < A_BYTES; i++) begin
                if (wr_addr == ADDR_W'(i))
                    opa[i*BYTE_W +: BYTE_W] <= wr_data;
            end
            if (wr_addr == ADR_BLO)
                opb[BYTE_W-1:0] <= wr_data;
            if (wr_addr == ADR_BDIV || wr_addr == ADR_BMUL || wr_addr == ADR_BHI)
                opb[B_W-1:BYTE_W] <= wr_data;
            if (wr_addr == ADR_SHF || wr_addr == ADR_CNT)
                shcnt <= wr_data[C_W-1:0];
            if (start)
                ahi <= 1'b0;
            else if (wr_addr >= ADDR_W'(B_BYTES) && wr_addr < ADDR_W'(A_BYTES))
                ahi <= 1'b1;
        end
    end
endmodule

// File: rtl/mdu_core.sv
module mdu_core
    import mdu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  op_e            op,
    input  logic           sgn,
    input  logic [A_W-1:0] opa,
    input  logic [B_W-1:0] opb,
    input  logic [C_W-1:0] shcnt,
    output logic           busy,
    output logic [A_W-1:0] res,
    output logic [B_W-1:0] rem,
    output logic           err,
    output logic [C_W-1:0] ncnt
);
    st_e            st, st_nx;
    op_e            op_q;
    logic           sgn_q, negq, negr, dz;
    logic [A_W-1:0] work;
    logic [B_W-1:0] pr, dv;
    logic [IT_W-1:0] cnt;

    logic [A_W-1:0] abs_a32;
    logic [B_W-1:0] abs_a16, abs_b;
    logic [B_W:0]   trial, diff, psum;
    logic           ge, zero_b, skip, last;

    always_comb begin
        abs_a32 = (sgn_q && opa[A_W-1]) ? -opa : opa;
        abs_a16 = (sgn_q && opa[B_W-1]) ? -opa[B_W-1:0] : opa[B_W-1:0];
        abs_b   = (sgn_q && opb[B_W-1]) ? -opb : opb;
        trial   = {pr, work[A_W-1]};
        diff    = trial - {1'b0, dv};
        ge      = trial >= {1'b0, dv};
        psum    = {1'b0, work[A_W-1:B_W]} + (work[0] ? {1'b0, dv} : '0);
        zero_b  = (opb == '0);
        case (op_q)
            OP_DIV32, OP_DIV16: skip = zero_b;
            OP_MUL:             skip = 1'b0;
            OP_NORM:            skip = (opa == '0) || opa[A_W-1];
            default:            skip = (shcnt == '0);
        endcase
        last = (op_q == OP_NORM) ? work[A_W-2] : (cnt == IT_W'(1));
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_PREP;
            ST_PREP: st_nx = skip ? ST_FIX : ST_RUN;
            ST_RUN:  if (last) st_nx = ST_FIX;
            ST_FIX:  st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    assign busy = (st != ST_IDLE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_DIV32; sgn_q <= 1'b0; negq <= 1'b0; negr <= 1'b0; dz <= 1'b0;
            work <= '0; pr <= '0; dv <= '0; cnt <= '0;
            res  <= '0; rem <= '0; err <= 1'b0; ncnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= op;
                        sgn_q <= sgn;
                    end
                end
                ST_PREP: begin
                    err <= 1'b0; ncnt <= '0; dz <= 1'b0; pr <= '0;
                    negq <= 1'b0; negr <= 1'b0;
                    case (op_q)
                        OP_DIV32: begin
                            work <= abs_a32; dv <= abs_b; cnt <= IT_W'(A_W);
                            negq <= sgn_q & (opa[A_W-1] ^ opb[B_W-1]);
                            negr <= sgn_q & opa[A_W-1];
                            dz <= zero_b; err <= zero_b;
                        end
                        OP_DIV16: begin
                            work <= {abs_a16, {(A_W-B_W){1'b0}}}; dv <= abs_b; cnt <= IT_W'(B_W);
                            negq <= sgn_q & (opa[B_W-1] ^ opb[B_W-1]);
                            negr <= sgn_q & opa[B_W-1];
                            dz <= zero_b; err <= zero_b;
                        end
                        OP_MUL: begin
                            work <= {{(A_W-B_W){1'b0}}, abs_a16}; dv <= abs_b; cnt <= IT_W'(B_W);
                            negq <= sgn_q & (opa[B_W-1] ^ opb[B_W-1]);
                        end
                        default: begin
                            work <= opa; cnt <= {1'b0, shcnt};
                        end
                    endcase
                end
                ST_RUN: begin
                    cnt <= cnt - 1'b1;
                    case (op_q)
                        OP_DIV32, OP_DIV16: begin
                            pr   <= ge ? diff[B_W-1:0] : trial[B_W-1:0];
                            work <= {work[A_W-2:0], ge};
                        end
                        OP_MUL:  work <= {psum, work[B_W-1:1]};
                        OP_NORM: begin
                            work <= work << 1;
                            ncnt <= ncnt + 1'b1;
                        end
                        OP_SHL:  work <= work << 1;
                        default: work <= {sgn_q & work[A_W-1], work[A_W-1:1]};
                    endcase
                end
                ST_FIX: begin
                    if (dz) begin
                        res <= (op_q == OP_DIV32) ? '1 : {{(A_W-B_W){1'b0}}, {B_W{1'b1}}};
                        rem <= opa[B_W-1:0];
                    end else begin
                        case (op_q)
                            OP_DIV32: begin
                                res <= negq ? -work : work;
                                rem <= negr ? -pr : pr;
                            end
                            OP_DIV16: begin
                                res <= {{(A_W-B_W){1'b0}}, negq ? -work[B_W-1:0] : work[B_W-1:0]};
                                rem <= negr ? -pr : pr;
                            end
                            OP_MUL: begin
                                res <= negq ? -work : work;
                                rem <= '0;
                            end
                            default: begin
                                res <= work;
                                rem <= '0;
                            end
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [RADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               busy
);
    logic           start_w, sgn_w, err_w;
    op_e            op_w;
    logic [A_W-1:0] opa_w, res_w;
    logic [B_W-1:0] opb_w, rem_w;
    logic [C_W-1:0] shcnt_w, ncnt_w;

    mdu_regs i_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .opa(opa_w), .opb(opb_w), .shcnt(shcnt_w),
        .start(start_w), .op(op_w), .sgn(sgn_w)
    );

    mdu_core i_core (
        .clk(clk), .rst_n(rst_n), .start(start_w), .op(op_w), .sgn(sgn_w),
        .opa(opa_w), .opb(opb_w), .shcnt(shcnt_w),
        .busy(busy), .res(res_w), .rem(rem_w), .err(err_w), .ncnt(ncnt_w)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            3'd0: rd_data = res_w[0*BYTE_W +: BYTE_W];
            3'd1: rd_data = res_w[1*BYTE_W +: BYTE_W];
            3'd2: rd_data = res_w[2*BYTE_W +: BYTE_W];
            3'd3: rd_data = res_w[3*BYTE_W +: BYTE_W];
            3'd4: rd_data = rem_w[0 +: BYTE_W];
            3'd5: rd_data = rem_w[BYTE_W +: BYTE_W];
            3'd6: rd_data = {busy, err_w, 1'b0, ncnt_w};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        busy,
    input logic        start,
    input logic [31:0] opa,
    input logic [15:0] opb,
    input logic [31:0] res,
    input logic        err
);
    logic [6:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    a_r2_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 7'd34);

    a_r12_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(opa) && $stable(opb)));

    a_r12_result_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(res));

    a_r11_err_inside_op: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> busy);
endmodule

bind mdu_top mdu_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .start(start_w),
    .opa(opa_w), .opb(opb_w), .res(res_w), .err(err_w)
);

// File: tb/test_mdu_top.sv
`timescale 1ns/1ps
module test_mdu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int nvec = 0;
    int nerr = 0;

    mdu_top i_mdu_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic set_a(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'(i), v[i*8 +: 8]);
    endtask

    task automatic set_a16(input logic [15:0] v);
        wr(4'd0, v[7:0]);
        wr(4'd1, v[15:8]);
    endtask

    task automatic set_b(input logic [15:0] v);
        wr(4'd4, v[7:0]);
        wr(4'd10, v[15:8]);
    endtask

    // start an operation, compare busy on every clock, then read back
    task automatic go(input logic [3:0] adr, input logic [7:0] d, input int lat,
                      input logic [31:0] er, input logic [15:0] erm, input logic [7:0] est,
                      input string tag, input bit meddle);
        logic [7:0] b;
        logic [31:0] r32;
        logic [15:0] r16;
        wr(adr, d);
        for (int k = 0; k < lat; k++) begin
            chk({tag, " busy"}, 32'(busy), 32'd1);
            if (meddle && k == 1) begin wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h00; end
            if (meddle && k == 2) wr_en = 1'b0;
            @(negedge clk);
        end
        chk({tag, " busy low"}, 32'(busy), 32'd0);
        for (int i = 0; i < 4; i++) begin rd(3'(i), b); r32[i*8 +: 8] = b; end
        rd(3'd4, b); r16[7:0] = b;
        rd(3'd5, b); r16[15:8] = b;
        chk({tag, " result"}, r32, er);
        chk({tag, " remainder"}, 32'(r16), 32'(erm));
        rd(3'd6, b);
        chk({tag, " status"}, 32'(b), 32'(est));
    endtask

    function automatic logic [47:0] divref(input logic [31:0] a, input logic [15:0] bv,
                                           input bit s, input bit w32);
        longint sa, sb, q, r;
        if (w32) sa = s ? longint'($signed(a)) : longint'(a);
        else     sa = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
        sb = s ? longint'($signed(bv)) : longint'(bv);
        q = sa / sb;
        r = sa % sb;
        return {r[15:0], w32 ? q[31:0] : {16'h0, q[15:0]}};
    endfunction

    function automatic logic [31:0] mulref(input logic [15:0] a, input logic [15:0] bv, input bit s);
        longint p;
        if (s) p = longint'($signed(a)) * longint'($signed(bv));
        else   p = longint'(a) * longint'(bv);
        return p[31:0];
    endfunction

    function automatic int lzc(input logic [31:0] v);
        int n = 0;
        if (v == 0) return 0;
        while (!v[31]) begin v = v << 1; n++; end
        return n;
    endfunction

    initial begin
        #(200000 * 20);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [47:0] dr;
        logic [7:0]  b;
        logic [31:0] av;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        for (int i = 0; i < 7; i++) begin rd(3'(i), b); chk("R1 byte", 32'(b), 32'd0); end

        // R2: legacy 32/16 unsigned divide
        set_a(32'h12345678); wr(4'd4, 8'h34);
        dr = divref(32'h12345678, 16'h1234, 0, 1);
        go(4'd5, 8'h12, 34, dr[31:0], dr[47:32], 8'h00, "R2 div32", 0);
        set_a(32'hFFFFFFFF); wr(4'd4, 8'hFD);
        dr = divref(32'hFFFFFFFF, 16'h00FD, 0, 1);
        go(4'd5, 8'h00, 34, dr[31:0], dr[47:32], 8'h00, "R2 div32 b", 0);

        // R3: legacy 16/16 divide (only low A bytes written since last start)
        set_a16(16'hBEEF); wr(4'd4, 8'h13);
        dr = divref(32'h0000BEEF, 16'h0013, 0, 0);
        go(4'd5, 8'h00, 18, dr[31:0], dr[47:32], 8'h00, "R3 div16", 0);

        // R4: legacy multiply
        set_a16(16'hFFFF); wr(4'd4, 8'hFF);
        go(4'd6, 8'hFF, 18, mulref(16'hFFFF, 16'hFFFF, 0), 16'h0, 8'h00, "R4 mul", 0);
        set_a16(16'h1234); wr(4'd4, 8'h05);
        go(4'd6, 8'h00, 18, mulref(16'h1234, 16'h0005, 0), 16'h0, 8'h00, "R4 mul b", 0);

        // R5: normalize
        av = 32'h00012345; set_a(av); n = lzc(av);
        go(4'd7, 8'h40, n + 2, av << n, 16'h0, 8'(n), "R5 norm", 0);
        set_a(32'h0);
        go(4'd7, 8'h40, 2, 32'h0, 16'h0, 8'h00, "R5 norm zero", 0);
        set_a(32'h80000000);
        go(4'd7, 8'h40, 2, 32'h80000000, 16'h0, 8'h00, "R5 norm msb", 0);

        // R6: legacy logical shifts
        av = 32'h80000001; set_a(av);
        go(4'd7, 8'h24, 6, av >> 4, 16'h0, 8'h00, "R6 shr4", 0);
        go(4'd7, 8'h1F, 33, av << 31, 16'h0, 8'h00, "R6 shl31", 0);
        go(4'd7, 8'h20, 2, av, 16'h0, 8'h00, "R6 count0", 0);

        // R7: opcode mode, unsigned operations and an invalid code
        set_a(32'h00001000); set_b(16'h0100);
        go(4'd8, 8'h00, 34, 32'h10, 16'h0, 8'h00, "R7 op0", 0);
        dr = divref(32'h00001000, 16'h0100, 0, 0);
        go(4'd8, 8'h01, 18, dr[31:0], dr[47:32], 8'h00, "R7 op1", 0);
        wr(4'd9, 8'h03);
        go(4'd8, 8'h04, 5, 32'h00008000, 16'h0, 8'h00, "R7 op4", 0);
        wr(4'd8, 8'h07);
        chk("R7 invalid busy", 32'(busy), 32'd0);
        for (int i = 0; i < 4; i++) begin rd(3'(i), b); av[i*8 +: 8] = b; end
        chk("R7 invalid result", av, 32'h00008000);

        // R8: signed multiply
        set_a16(16'hFFFD); set_b(16'h0007);
        go(4'd8, 8'h0A, 18, mulref(16'hFFFD, 16'h0007, 1), 16'h0, 8'h00, "R8 smul", 0);
        set_a16(16'h8000); set_b(16'h8000);
        go(4'd8, 8'h0A, 18, mulref(16'h8000, 16'h8000, 1), 16'h0, 8'h00, "R8 smul min", 0);

        // R9: signed divide
        set_a(32'hFFFFFF9C); set_b(16'h0007);
        dr = divref(32'hFFFFFF9C, 16'h0007, 1, 1);
        go(4'd8, 8'h08, 34, dr[31:0], dr[47:32], 8'h00, "R9 sdiv32", 0);
        set_b(16'hFFF9);
        dr = divref(32'hFFFFFF9C, 16'hFFF9, 1, 1);
        go(4'd8, 8'h08, 34, dr[31:0], dr[47:32], 8'h00, "R9 sdiv32 negb", 0);
        set_a16(16'h8000); set_b(16'hFFFF);
        dr = divref(32'h00008000, 16'hFFFF, 1, 0);
        go(4'd8, 8'h09, 18, dr[31:0], dr[47:32], 8'h00, "R9 sdiv16", 0);

        // R10: arithmetic shifts
        av = 32'h80000010; set_a(av); wr(4'd9, 8'h04);
        go(4'd8, 8'h0D, 6, 32'hF8000001, 16'h0, 8'h00, "R10 sar", 0);
        go(4'd8, 8'h05, 6, av >> 4, 16'h0, 8'h00, "R10 shr", 0);
        go(4'd8, 8'h0C, 6, av << 4, 16'h0, 8'h00, "R10 sal", 0);

        // R11: zero divisor
        set_a(32'h12345678); wr(4'd4, 8'h00);
        go(4'd5, 8'h00, 2, 32'hFFFFFFFF, 16'h5678, 8'h40, "R11 div32 zero", 0);
        set_a16(16'h00AB);
        go(4'd5, 8'h00, 2, 32'h0000FFFF, 16'h00AB, 8'h40, "R11 div16 zero", 0);
        wr(4'd4, 8'h02);
        go(4'd6, 8'h00, 18, 32'h00000156, 16'h0, 8'h00, "R11 err cleared", 0);

        // R12: writes during busy are ignored
        set_a16(16'hF000); wr(4'd4, 8'h05);
        dr = divref(32'h0000F000, 16'h0105, 0, 0);
        go(4'd5, 8'h01, 18, dr[31:0], dr[47:32], 8'h00, "R12 busy write", 1);
        go(4'd8, 8'h01, 18, dr[31:0], dr[47:32], 8'h00, "R12 operand kept", 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule